// File: doc/BRIEF.md
# 20-bit Integer ALU with Packed Status Word

This block is the integer and bitwise arithmetic unit of a small 20-bit processor. The decoder hands it two 20-bit operands, a 4-bit operation code and the current 20-bit status word, and pulses `start`. The block returns a 20-bit result, a write-enable for the destination (normally the sum register), and the status word with its condition flags updated. The upper four status bits are flags. From bit 19 down they are OW (overflow), Z (zero), N (negative) and E (error). Bits 15:0 hold interrupt and reset progress and availability fields that this block never alters.

All operations except divide finish in a single cycle. Divide runs through an iterative signed divider taking one step per result bit. While it runs, `busy` is high and any new `start` is dropped. Every accepted operation ends with exactly one `done` pulse. `result`, `wr_en` and `stat_out` are valid in that cycle and hold until the next operation completes.

Operation codes: 0 add, 1 subtract, 2 multiply, 3 divide, 4 OR, 5 AND, 6 XOR, 7 increment, 8 decrement. Codes 9 to 15 are unused.

Top module: `alu20_core`

## Requirements
- R1: Add (code 0) gives opa+opb and subtract (code 1) gives opa-opb, both modulo 2^20. OW (bit 19) is set exactly on signed two's-complement overflow. Z (bit 18) is set when the result is zero. N (bit 17) equals result bit 19. E (bit 16) is unchanged.
- R2: Multiply (code 2) returns the low 20 bits of the signed product. OW is set exactly when the full signed product lies outside -524288..524287. Z and N follow R1, and E is unchanged.
- R3: OR, AND and XOR (codes 4, 5, 6) act on the raw bit patterns. They clear OW, set Z and N from the result as in R1, and leave E unchanged.
- R4: Divide (code 3) with a nonzero divisor returns the signed quotient opa/opb truncated toward zero, and asserts `wr_en`. It clears E, sets Z and N from the quotient, and leaves OW unchanged. The case -524288/-1 wraps to 0x80000.
- R5: Divide by zero asserts `done` one cycle after `start` with `wr_en` low. `result` keeps its previous value. E is set, and OW, Z and N keep their input values.
- R6: Increment (code 7) and decrement (code 8) return opa+1 and opa-1 modulo 2^20 with `wr_en` high. The status word is returned equal to `stat_in`.
- R7: `stat_out[15:0]` always equals bits 15:0 of the `stat_in` sampled with the accepted `start`.
- R8: A non-divide operation, or a divide by zero, pulses `done` for one cycle starting at the clock edge that samples `start`. A divide with a nonzero divisor raises `busy` at that edge and pulses `done` after 21 further edges. `start` while `busy` is ignored and produces no extra `done`.
- R9: Codes 9 to 15 pulse `done` with `wr_en` low. `result` stays unchanged and `stat_out` equals `stat_in`.
- R10: After reset `result`, `stat_out`, `done`, `busy` and `wr_en` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Accept an operation this cycle (ignored while busy) |
| op | input | 4 | Operation code |
| opa | input | 20 | First operand |
| opb | input | 20 | Second operand |
| stat_in | input | 20 | Current status word |
| busy | output | 1 | Divide in progress |
| done | output | 1 | One-cycle completion pulse |
| wr_en | output | 1 | Result is to be written to the destination |
| result | output | 20 | Operation result |
| stat_out | output | 20 | Updated status word |

## Verification
The bench aims at the edges of signed overflow. It covers positive and negative add and subtract overflow, and products that fit only through their sign bits. A design that tested overflow on the unsigned carry, or only on the upper product half, would flag the wrong cases. Divides use mixed signs, the minimum value over -1, and a zero divisor. Rounding toward minus infinity, writing the destination on a zero divisor, or touching OW during a divide would each show up as a wrong result, write or status bit. The bench also feeds status words with set flags and patterned low bits through increment, decrement, bitwise and unused codes, so that a design that clears untouched flags or the bookkeeping fields is exposed. A `start` pulsed in the middle of a divide would corrupt the quotient or add a second `done` in a design that failed to ignore it.

// File: rtl/alu20_pkg.sv
package alu20_pkg;
  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_MUL = 4'd2,
    OP_DIV = 4'd3,
    OP_OR  = 4'd4,
    OP_AND = 4'd5,
    OP_XOR = 4'd6,
    OP_INC = 4'd7,
    OP_DEC = 4'd8
  } alu_op_e;

  // flag positions counted down from the word MSB
  localparam int unsigned FLG_OW_OFS = 1;
  localparam int unsigned FLG_Z_OFS  = 2;
  localparam int unsigned FLG_N_OFS  = 3;
  localparam int unsigned FLG_E_OFS  = 4;
endpackage

// File: rtl/alu20_single.sv
module alu20_single
  import alu20_pkg::*;
#(
  parameter int unsigned W = 20
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] stat_in,
  output logic [W-1:0] res,
  output logic [W-1:0] stat_nx,
  output logic         wr
);
  localparam int unsigned IOW = W - FLG_OW_OFS;
  localparam int unsigned IZ  = W - FLG_Z_OFS;
  localparam int unsigned IN  = W - FLG_N_OFS;

  logic [W-1:0]   sum, diff;
  logic [2*W-1:0] ax, bx, prod;
  logic [W:0]     prod_top;
  logic           ovf_add, ovf_sub, ovf_mul;
  logic           ow, upd;

  assign sum      = a + b;
  assign diff     = a - b;
  assign ax       = {{W{a[W-1]}}, a};
  assign bx       = {{W{b[W-1]}}, b};
  assign prod     = ax * bx;
  assign prod_top = prod[2*W-1:W-1];
  assign ovf_add  = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);
  assign ovf_sub  = (a[W-1] != b[W-1]) && (diff[W-1] != a[W-1]);
  assign ovf_mul  = !((&prod_top) || (~|prod_top));

  always_comb begin
    res = a;
    ow  = 1'b0;
    upd = 1'b1;
    wr  = 1'b1;
    case (op)
      OP_ADD:  begin res = sum;          ow = ovf_add; end
      OP_SUB:  begin res = diff;         ow = ovf_sub; end
      OP_MUL:  begin res = prod[W-1:0];  ow = ovf_mul; end
      OP_OR:   res = a | b;
      OP_AND:  res = a & b;
      OP_XOR:  res = a ^ b;
      OP_INC:  begin res = a + 1'b1; upd = 1'b0; end
      OP_DEC:  begin res = a - 1'b1; upd = 1'b0; end
      default: begin upd = 1'b0; wr = 1'b0; end
    endcase
  end

  always_comb begin
    stat_nx = stat_in;
    if (upd) begin
      stat_nx[IOW] = ow;
      stat_nx[IZ]  = (res == '0);
      stat_nx[IN]  = res[W-1];
    end
  end
endmodule

// File: rtl/alu20_divider.sv
module alu20_divider #(
  parameter int unsigned W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] dvd,
  input  logic [W-1:0] dvs,
  output logic         fin,
  output logic [W-1:0] quot
);
  localparam int unsigned CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic          run_q, run_nx, fin_q, fin_nx, neg_q, neg_nx;
  logic [CW-1:0] cnt_q, cnt_nx;
  logic [W-1:0]  rem_q, rem_nx, quo_q, quo_nx, div_q, div_nx;
  logic [W:0]    shifted, trial;

  assign shifted = {rem_q, quo_q[W-1]};
  assign trial   = shifted - {1'b0, div_q};

  always_comb begin
    run_nx = run_q;
    fin_nx = 1'b0;
    neg_nx = neg_q;
    cnt_nx = cnt_q;
    rem_nx = rem_q;
    quo_nx = quo_q;
    div_nx = div_q;
    if (go) begin
      run_nx = 1'b1;
      cnt_nx = '0;
      rem_nx = '0;
      neg_nx = dvd[W-1] ^ dvs[W-1];
      quo_nx = dvd[W-1] ? (~dvd + 1'b1) : dvd;
      div_nx = dvs[W-1] ? (~dvs + 1'b1) : dvs;
    end else if (run_q) begin
      rem_nx = trial[W] ? shifted[W-1:0] : trial[W-1:0];
      quo_nx = {quo_q[W-2:0], ~trial[W]};
      cnt_nx = cnt_q + 1'b1;
      if (cnt_q == LAST) begin
        run_nx = 1'b0;
        fin_nx = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      fin_q <= 1'b0;
      neg_q <= 1'b0;
      cnt_q <= '0;
      rem_q <= '0;
      quo_q <= '0;
      div_q <= '0;
    end else begin
      run_q <= run_nx;
      fin_q <= fin_nx;
      neg_q <= neg_nx;
      cnt_q <= cnt_nx;
      rem_q <= rem_nx;
      quo_q <= quo_nx;
      div_q <= div_nx;
    end
  end

  assign fin  = fin_q;
  assign quot = neg_q ? (~quo_q + 1'b1) : quo_q;

  // R8: completion of one divide is a single-cycle pulse
  p_fin_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fin_q |=> !fin_q);
endmodule

// File: rtl/alu20_core.sv
module alu20_core
  import alu20_pkg::*;
#(
  parameter int unsigned W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [3:0]   op,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic [W-1:0] stat_in,
  output logic         busy,
  output logic         done,
  output logic         wr_en,
  output logic [W-1:0] result,
  output logic [W-1:0] stat_out
);
  localparam int unsigned IZ = W - FLG_Z_OFS;
  localparam int unsigned IN = W - FLG_N_OFS;
  localparam int unsigned IE = W - FLG_E_OFS;

  logic         busy_q, busy_nx, done_q, done_nx, wr_q, wr_nx;
  logic [W-1:0] res_q, res_nx, st_q, st_nx, base_q, base_nx;
  logic [3:0]   op_q, op_nx;
  logic [W-1:0] s_res, s_stat, quot;
  logic         s_wr, accept, is_div, dz, div_go, div_fin;

  assign accept = start && !busy_q;
  assign is_div = (op == OP_DIV);
  assign dz     = (opb == '0);
  assign div_go = accept && is_div && !dz;

  alu20_single #(.W(W)) u_single (
    .op(op), .a(opa), .b(opb), .stat_in(stat_in),
    .res(s_res), .stat_nx(s_stat), .wr(s_wr)
  );

  alu20_divider #(.W(W)) u_div (
    .clk(clk), .rst_n(rst_n), .go(div_go), .dvd(opa), .dvs(opb),
    .fin(div_fin), .quot(quot)
  );

  always_comb begin
    busy_nx = busy_q;
    done_nx = 1'b0;
    wr_nx   = wr_q;
    res_nx  = res_q;
    st_nx   = st_q;
    base_nx = base_q;
    op_nx   = op_q;
    if (accept) begin
      op_nx = op;
      if (is_div && dz) begin
        st_nx     = stat_in;
        st_nx[IE] = 1'b1;
        wr_nx     = 1'b0;
        done_nx   = 1'b1;
      end else if (is_div) begin
        busy_nx = 1'b1;
        base_nx = stat_in;
      end else begin
        if (s_wr) res_nx = s_res;
        st_nx   = s_stat;
        wr_nx   = s_wr;
        done_nx = 1'b1;
      end
    end else if (busy_q && div_fin) begin
      busy_nx   = 1'b0;
      res_nx    = quot;
      st_nx     = base_q;
      st_nx[IE] = 1'b0;
      st_nx[IZ] = (quot == '0);
      st_nx[IN] = quot[W-1];
      wr_nx     = 1'b1;
      done_nx   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      wr_q   <= 1'b0;
      res_q  <= '0;
      st_q   <= '0;
      base_q <= '0;
      op_q   <= '0;
    end else begin
      busy_q <= busy_nx;
      done_q <= done_nx;
      wr_q   <= wr_nx;
      res_q  <= res_nx;
      st_q   <= st_nx;
      base_q <= base_nx;
      op_q   <= op_nx;
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign wr_en    = wr_q;
  assign result   = res_q;
  assign stat_out = st_q;

  // R1 (also R2, R3, R4): Z follows the written result for flag-updating ops
  p_zero_flag_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (done && wr_en && op_q != OP_INC && op_q != OP_DEC) |->
      (stat_out[IZ] == (result == '0)));
  // R1: N follows the sign of the written result
  p_neg_flag_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (done && wr_en && op_q != OP_INC && op_q != OP_DEC) |->
      (stat_out[IN] == result[W-1]));
  // R5: a reported divide error never writes the destination
  p_divzero_nowr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q == OP_DIV && stat_out[IE]) |-> !wr_en);
  // R9: unused codes never write
  p_rsv_nowr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q > OP_DEC) |-> !wr_en);
  // R8: busy only falls together with a completion pulse
  p_busy_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
endmodule

// File: tb/alu20_core_tb.sv
module alu20_core_tb;
  localparam int W = 20;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [3:0] op = '0;
  logic [W-1:0] opa = '0, opb = '0, stat_in = '0;
  logic busy, done, wr_en;
  logic [W-1:0] result, stat_out;

  int total = 0;
  int bad = 0;
  logic [W-1:0] last_res = '0;

  always #5 clk = ~clk;

  alu20_core #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .opa(opa), .opb(opb),
    .stat_in(stat_in), .busy(busy), .done(done), .wr_en(wr_en),
    .result(result), .stat_out(stat_out)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic longint sx(input logic [W-1:0] v);
    return longint'($signed(v));
  endfunction

  // reference from the requirements
  task automatic model(input logic [3:0] o, input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic [W-1:0] s, output logic [W-1:0] er,
                       output logic [W-1:0] es, output logic ew);
    longint r;
    logic [63:0] rb;
    er = last_res; es = s; ew = 1'b1;
    case (o)
      4'd0, 4'd1, 4'd2: begin
        r = (o == 4'd0) ? sx(a) + sx(b) : (o == 4'd1) ? sx(a) - sx(b) : sx(a) * sx(b);
        rb = r; er = rb[W-1:0];
        es[19] = (r > 524287) || (r < -524288);
        es[18] = (er == 0); es[17] = er[19];
      end
      4'd3: begin
        if (b == 0) begin
          ew = 1'b0; es[16] = 1'b1;
        end else begin
          r = sx(a) / sx(b); rb = r; er = rb[W-1:0];
          es[16] = 1'b0; es[18] = (er == 0); es[17] = er[19];
        end
      end
      4'd4, 4'd5, 4'd6: begin
        er = (o == 4'd4) ? (a | b) : (o == 4'd5) ? (a & b) : (a ^ b);
        es[19] = 1'b0; es[18] = (er == 0); es[17] = er[19];
      end
      4'd7: er = a + 1'b1;
      4'd8: er = a - 1'b1;
      default: ew = 1'b0;
    endcase
  endtask

  task automatic run_op(input string tag, input logic [3:0] o, input logic [W-1:0] a,
                        input logic [W-1:0] b, input logic [W-1:0] s);
    logic [W-1:0] er, es;
    logic ew;
    int waited;
    model(o, a, b, s, er, es, ew);
    @(negedge clk);
    op = o; opa = a; opb = b; stat_in = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0; stat_in = ~s;
    waited = 0;
    while (!done && waited < 40) begin
      @(negedge clk);
      waited++;
    end
    chk({tag, " done"}, {19'd0, done}, 20'd1);
    chk({tag, " result"}, result, er);
    chk({tag, " status"}, stat_out, es);
    chk({tag, " wr_en"}, {19'd0, wr_en}, {19'd0, ew});
    if (ew) last_res = er;
  endtask

  task automatic t_reset_r10();
    chk("R10 result", result, '0);
    chk("R10 status", stat_out, '0);
    chk("R10 flags", {17'd0, done, busy, wr_en}, '0);
  endtask

  task automatic t_addsub_r1();
    run_op("R1 add plain", 4'd0, 20'h00123, 20'h00456, 20'h0A5A5);
    run_op("R1 add pos ovf", 4'd0, 20'h7FFFF, 20'h00001, 20'h00000);
    run_op("R1 add neg ovf", 4'd0, 20'h80000, 20'hFFFFF, 20'h00000);
    run_op("R1 add zero", 4'd0, 20'hFFFFF, 20'h00001, 20'h80000);
    run_op("R1 sub neg", 4'd1, 20'h00003, 20'h00005, 20'h10000);
    run_op("R1 sub ovf", 4'd1, 20'h80000, 20'h00001, 20'h00000);
  endtask

  task automatic t_mul_r2();
    run_op("R2 mul fit", 4'd2, 20'h003E8, 20'hFFE0C, 20'h00000);
    run_op("R2 mul ovf", 4'd2, 20'h01000, 20'h01000, 20'h00000);
    run_op("R2 mul edge", 4'd2, 20'h40000, 20'hFFFFE, 20'h80000);
    run_op("R2 mul negneg", 4'd2, 20'hFFFF9, 20'hFFFFD, 20'h10000);
  endtask

  task automatic t_bitwise_r3();
    run_op("R3 or", 4'd4, 20'hF0F00, 20'h0F0F0, 20'h9FFFF);
    run_op("R3 and", 4'd5, 20'hF0F00, 20'h0F0F0, 20'h80000);
    run_op("R3 xor", 4'd6, 20'hAAAAA, 20'h55555, 20'h1C3C3);
  endtask

  task automatic t_div_r4();
    run_op("R4 div pos", 4'd3, 20'd100, 20'd7, 20'h93333);
    run_op("R4 div trunc", 4'd3, 20'hFFFF9, 20'd2, 20'h00000);
    run_op("R4 div negneg", 4'd3, 20'hFFFF9, 20'hFFFFE, 20'h80000);
    run_op("R4 div small", 4'd3, 20'd3, 20'd9, 20'h00000);
    run_op("R4 div min", 4'd3, 20'h80000, 20'hFFFFF, 20'h00000);
  endtask

  task automatic t_divzero_r5();
    run_op("R5 div zero", 4'd3, 20'h12345, 20'h00000, 20'h6ABCD);
  endtask

  task automatic t_incdec_r6();
    run_op("R6 inc wrap", 4'd7, 20'hFFFFF, 20'h00000, 20'hD1234);
    run_op("R6 dec wrap", 4'd8, 20'h00000, 20'h00000, 20'h2FFFF);
  endtask

  task automatic t_lowbits_r7();
    run_op("R7 low keep add", 4'd0, 20'h00001, 20'h00001, 20'h0FFFF);
    run_op("R7 low keep div", 4'd3, 20'd50, 20'd5, 20'h0C3A5);
  endtask

  task automatic t_timing_r8();
    int edges;
    logic [W-1:0] er, es;
    logic ew;
    @(negedge clk);
    op = 4'd0; opa = 20'd1; opb = 20'd2; stat_in = 20'h0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R8 single done", {19'd0, done}, 20'd1);
    @(negedge clk);
    chk("R8 single pulse", {19'd0, done}, 20'd0);
    last_res = 20'd3;
    model(4'd3, 20'd1000, 20'd10, 20'h00000, er, es, ew);
    op = 4'd3; opa = 20'd1000; opb = 20'd10; start = 1'b1;
    @(negedge clk);
    chk("R8 busy", {19'd0, busy}, 20'd1);
    op = 4'd0; opa = 20'd5; opb = 20'd5; stat_in = 20'hFFFFF;
    edges = 1;
    while (!done && edges < 60) begin
      @(negedge clk);
      start = 1'b0;
      edges++;
    end
    start = 1'b0;
    chk("R8 div latency", 20'(edges), 20'd22);
    chk("R8 div result", result, er);
    chk("R8 div status", stat_out, es);
    last_res = er;
    @(negedge clk);
    chk("R8 no extra done", {18'd0, done, busy}, 20'd0);
  endtask

  task automatic t_reserved_r9();
    run_op("R9 code9", 4'd9, 20'h11111, 20'h22222, 20'hE5555);
    run_op("R9 code15", 4'd15, 20'h33333, 20'h44444, 20'h00000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_r10();
    rst_n = 1'b1;
    t_addsub_r1();
    t_mul_r2();
    t_bitwise_r3();
    t_div_r4();
    t_divzero_r5();
    t_incdec_r6();
    t_lowbits_r7();
    t_timing_r8();
    t_reserved_r9();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule